// File: doc/BRIEF.md
# ATA Channel Interrupt Status Unit

This block collects the interrupt conditions of a single ATA channel and presents them to the host as a level interrupt line. Two sources feed it: a device/DMA-completion event and a bus-error-during-DMA event. Each event latches a sticky status bit. Software reads the status word and writes ones back to clear it. A separate pair of write-only-by-ones registers turns each source's interrupt contribution on or off. When a bus error is recorded, the block captures the faulting bus address and holds it in two readable words.

The block also watches the host's reads of the ATA device status register. When such a read returns a status byte that shows the device is no longer busy and has something to report, the block clears both pending status bits by itself. A driver can then drop a pending interrupt just by reading the device status, without a second register write.

All registers sit on a small word-indexed read/write port. Reads are combinational on the index. Writes and events take effect at the next clock edge.

Top module: `atairq_status_unit`

## Requirements
- R1: After a synchronous active-low reset, the status bits, enable bits, captured fault address and irq_o are all zero.
- R2: A pulse on ev_dev sets status bit 0, and a pulse on ev_bus_err sets status bit 1, on the next clock edge, whatever the enables. Status is read at word index 3 in bits 1:0, with all other bits zero.
- R3: A write to word index 5 sets every enable bit whose data bit is 1 and leaves the others unchanged. The enables read back at index 5 in bits 1:0.
- R4: A write to word index 7 clears every enable bit whose data bit is 1. If the same bit is set and cleared in one cycle, the set wins.
- R5: irq_o is high exactly while some status bit is set and its enable bit is set. A status bit whose enable is clear does not drive irq_o.
- R6: A write to word index 3 clears, on the next edge, each status bit whose data bit is 1. Writing 0x03 clears both bits, and data bits that are 0 leave their status bits unchanged.
- R7: An event that arrives in the same cycle as a clear of its bit leaves the bit set. This holds for both a register clear and a snoop clear.
- R8: On a bus-error event, the fault address is captured only while status bit 1 is clear. The low 32 bits read at word index 0 and the high 32 bits at index 1. Later bus errors do not overwrite the address until bit 1 has been cleared.
- R9: A snooped read (snp_rd high) at byte address 0x11C whose returned status byte has any of bits 0x51 set clears both status bits on the next edge.
- R10: A snooped read at any other byte address, or one whose status byte has none of the bits 0x51 set (for example 0x80, busy), leaves the status bits unchanged.
- R11: Word indices 2, 4 and 6 read as zero. Writes to indices 0 and 1 leave the captured fault address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Word index for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx (combinational) |
| ev_dev | input | 1 | Device/DMA interrupt event pulse |
| ev_bus_err | input | 1 | Bus error during DMA event pulse |
| bus_err_addr | input | 64 | Faulting bus address, valid with ev_bus_err |
| snp_rd | input | 1 | Host read observed on the ATA register space |
| snp_addr | input | 12 | Byte address of the observed read |
| snp_data | input | 8 | Byte returned by the observed read |
| irq_o | output | 1 | Level interrupt request |

## Verification
Events are raised with the enables off and then with them on. This separates the sticky status bits from the interrupt output. A single enable bit is also cleared while its status bit stays set. Clears are applied alone and in the same cycle as a new event, which shows whether a clear can drop an event. Repeated bus errors with different addresses show whether the first fault address is kept. The snoop path is driven with the matching address and a ready byte, with a busy byte, and with a neighbouring address. This tells a correct address-and-mask decode apart from one that ignores either the address or the data.

// File: rtl/atairq_pkg.sv
// Package: shared register indices and decode types for the ATA interrupt
// status unit. Assumes a word-indexed register port of at least 3 bits.
package atairq_pkg;
    localparam int NSRC       = 2;  // bit 0 device event, bit 1 bus error
    localparam int IDX_ERR_LO = 0;
    localparam int IDX_ERR_HI = 1;
    localparam int IDX_STATUS = 3;
    localparam int IDX_EN_SET = 5;
    localparam int IDX_EN_CLR = 7;

    typedef struct packed {
        logic st_clr;
        logic en_set;
        logic en_clr;
        logic err_wr;
    } wr_dec_t;
endpackage

// File: rtl/atairq_decode.sv
// Module: register write decoder. Turns a write strobe and word index into
// one-hot register strokes. Assumes index width of at least 3 bits.
module atairq_decode
    import atairq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    output wr_dec_t          dec
);
    // Decode one register stroke per write.
    always_comb begin
        dec        = '0;
        dec.st_clr = we && (idx == IDX_W'(IDX_STATUS));
        dec.en_set = we && (idx == IDX_W'(IDX_EN_SET));
        dec.en_clr = we && (idx == IDX_W'(IDX_EN_CLR));
        dec.err_wr = we && ((idx == IDX_W'(IDX_ERR_LO)) || (idx == IDX_W'(IDX_ERR_HI)));
    end
endmodule

// File: rtl/atairq_snoop.sv
// Module: ATA status read snoop. Flags a host read of the device status
// register whose returned byte shows a ready condition. Purely combinational;
// assumes the snoop inputs are stable around the sampling clock edge.
module atairq_snoop #(
    parameter int               BADDR_W    = 12,
    parameter int               STAT_W     = 8,
    parameter logic [11:0]      STAT_ADDR  = 12'h11C,
    parameter logic [7:0]       READY_MASK = 8'h51
) (
    input  logic               rd,
    input  logic [BADDR_W-1:0] addr,
    input  logic [STAT_W-1:0]  data,
    output logic               hit
);
    localparam logic [BADDR_W-1:0] MATCH = BADDR_W'(STAT_ADDR);
    localparam logic [STAT_W-1:0]  MASK  = STAT_W'(READY_MASK);

    // Address match qualified by any ready bit in the returned byte.
    always_comb hit = rd && (addr == MATCH) && ((data & MASK) != '0);
endmodule

// File: rtl/atairq_w1c_bits.sv
// Module: per-source sticky status bit plus enable bit. Events set status,
// clear strokes drop it; an event in the same cycle as a clear wins.
// Enables are set and cleared by ones; set wins over clear.
module atairq_w1c_bits #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] st_clr,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    output logic [N-1:0] status,
    output logic [N-1:0] enable
);
    for (genvar i = 0; i < N; i++) begin : g_src
        // Sticky status: event has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          status[i] <= 1'b0;
            else if (ev[i])      status[i] <= 1'b1;
            else if (st_clr[i])  status[i] <= 1'b0;
        end

        // Enable bit: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          enable[i] <= 1'b0;
            else if (en_set[i])  enable[i] <= 1'b1;
            else if (en_clr[i])  enable[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/atairq_err_capture.sv
// Module: fault address capture. Records the bus address of a bus error
// only while no earlier bus error is pending, so the first fault is kept.
module atairq_err_capture #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_err,
    input  logic          pending,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_q
);
    // Capture on a fresh fault only.
    always_ff @(posedge clk) begin
        if (!rst_n)                 addr_q <= '0;
        else if (ev_err && !pending) addr_q <= addr_in;
    end
endmodule

// File: rtl/atairq_status_unit.sv
// Module: ATA channel interrupt status unit (top). Word-indexed registers:
// 0/1 fault address low/high, 3 status (write ones to clear), 5 enable set,
// 7 enable clear. A snooped ready read of the device status register clears
// both status bits. irq_o is the OR of enabled status bits.
module atairq_status_unit
    import atairq_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          IDX_W      = 3,
    parameter int          BADDR_W    = 12,
    parameter int          STAT_W     = 8,
    parameter logic [11:0] STAT_ADDR  = 12'h11C,
    parameter logic [7:0]  READY_MASK = 8'h51
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  ev_dev,
    input  logic                  ev_bus_err,
    input  logic [2*DATA_W-1:0]   bus_err_addr,
    input  logic                  snp_rd,
    input  logic [BADDR_W-1:0]    snp_addr,
    input  logic [STAT_W-1:0]     snp_data,
    output logic                  irq_o
);
    localparam int AW = 2 * DATA_W;

    wr_dec_t          dec;
    logic             snoop_hit;
    logic [NSRC-1:0]  ev_vec;
    logic [NSRC-1:0]  clr_vec;
    logic [NSRC-1:0]  status_q;
    logic [NSRC-1:0]  enable_q;
    logic [AW-1:0]    err_addr_q;
    logic [NSRC-1:0]  wr_bits;

    atairq_decode #(.IDX_W(IDX_W)) u_dec (
        .we  (reg_we),
        .idx (reg_idx),
        .dec (dec)
    );

    atairq_snoop #(
        .BADDR_W(BADDR_W), .STAT_W(STAT_W),
        .STAT_ADDR(STAT_ADDR), .READY_MASK(READY_MASK)
    ) u_snoop (
        .rd   (snp_rd),
        .addr (snp_addr),
        .data (snp_data),
        .hit  (snoop_hit)
    );

    // Gather events and clear strokes per source.
    always_comb begin
        wr_bits = reg_wdata[NSRC-1:0];
        ev_vec  = {ev_bus_err, ev_dev};
        clr_vec = ({NSRC{dec.st_clr}} & wr_bits) | {NSRC{snoop_hit}};
    end

    atairq_w1c_bits #(.N(NSRC)) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_vec),
        .st_clr (clr_vec),
        .en_set ({NSRC{dec.en_set}} & wr_bits),
        .en_clr ({NSRC{dec.en_clr}} & wr_bits),
        .status (status_q),
        .enable (enable_q)
    );

    atairq_err_capture #(.AW(AW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_err  (ev_bus_err),
        .pending (status_q[1]),
        .addr_in (bus_err_addr),
        .addr_q  (err_addr_q)
    );

    // Read multiplexer over the word index.
    always_comb begin
        reg_rdata = '0;
        if (reg_idx == IDX_W'(IDX_ERR_LO))      reg_rdata = err_addr_q[DATA_W-1:0];
        else if (reg_idx == IDX_W'(IDX_ERR_HI)) reg_rdata = err_addr_q[AW-1:DATA_W];
        else if (reg_idx == IDX_W'(IDX_STATUS)) reg_rdata = DATA_W'(status_q);
        else if (reg_idx == IDX_W'(IDX_EN_SET)) reg_rdata = DATA_W'(enable_q);
    end

    // Level interrupt from enabled status.
    always_comb irq_o = |(status_q & enable_q);
endmodule

// File: rtl/atairq_checker.sv
// Module: assertion checker for the ATA interrupt status unit, attached by
// bind. Observes ports plus the status, enable and captured-address state.
module atairq_checker
    import atairq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [IDX_W-1:0]    reg_idx,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                ev_dev,
    input logic                ev_bus_err,
    input logic                snoop_hit,
    input logic [NSRC-1:0]     status,
    input logic [NSRC-1:0]     enable,
    input logic [2*DATA_W-1:0] err_addr,
    input logic                irq_o
);
    logic clr_st0;
    logic set_en0;
    always_comb begin
        clr_st0 = reg_we && (reg_idx == IDX_W'(IDX_STATUS)) && reg_wdata[0];
        set_en0 = reg_we && (reg_idx == IDX_W'(IDX_EN_SET)) && reg_wdata[0];
    end

    // R1: reset empties all state
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && enable == '0 && err_addr == '0 && !irq_o));

    // R2: events set their status bits
    p_dev_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dev |=> status[0]);
    p_err_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_err |=> status[1]);

    // R3: enable set by ones
    p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en0 |=> enable[0]);

    // R5: no enables, no interrupt
    p_no_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq_o);

    // R6: write-one clears status bit 0
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_st0 && !ev_dev) |=> !status[0]);

    // R7: event beats a simultaneous clear
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_st0 || snoop_hit) && ev_dev) |=> status[0]);

    // R8: captured address held while a bus error is pending
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |=> $stable(err_addr));

    // R9: ready snoop clears both bits
    p_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit && !ev_dev && !ev_bus_err) |=> (status == '0));
endmodule

bind atairq_status_unit atairq_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_idx    (reg_idx),
    .reg_wdata  (reg_wdata),
    .ev_dev     (ev_dev),
    .ev_bus_err (ev_bus_err),
    .snoop_hit  (snoop_hit),
    .status     (status_q),
    .enable     (enable_q),
    .err_addr   (err_addr_q),
    .irq_o      (irq_o)
);

// File: tb/tb_atairq_status_unit.sv
// Bench: scoreboard. Driver tasks apply one cycle of stimulus each; read
// checks push an expected item, and a negedge monitor pops and compares.
module tb_atairq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_dev = 1'b0;
    logic        ev_bus_err = 1'b0;
    logic [63:0] bus_err_addr = '0;
    logic        snp_rd = 1'b0;
    logic [11:0] snp_addr = '0;
    logic [7:0]  snp_data = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;  // 50 MHz

    atairq_status_unit dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ev_dev(ev_dev), .ev_bus_err(ev_bus_err), .bus_err_addr(bus_err_addr),
        .snp_rd(snp_rd), .snp_addr(snp_addr), .snp_data(snp_data),
        .irq_o(irq_o)
    );

    // Monitor: compare each expected item at the negedge after it was queued.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (reg_rdata !== e.data || irq_o !== e.irq) begin
                errors++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, reg_rdata, irq_o, e.data, e.irq);
            end
        end
    end

    // One cycle of stimulus; all strobes set fresh.
    task automatic drive(input logic we, input logic [2:0] idx, input logic [31:0] wd,
                         input logic dv, input logic er, input logic [63:0] ea,
                         input logic sr, input logic [11:0] sa, input logic [7:0] sd);
        @(posedge clk); #1;
        reg_we = we; reg_idx = idx; reg_wdata = wd;
        ev_dev = dv; ev_bus_err = er; bus_err_addr = ea;
        snp_rd = sr; snp_addr = sa; snp_data = sd;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] wd);
        drive(1'b1, idx, wd, 1'b0, 1'b0, '0, 1'b0, '0, '0);
    endtask

    task automatic chk(input logic [2:0] idx, input logic [31:0] d, input logic irq,
                       input string tag);
        exp_t e;
        drive(1'b0, idx, '0, 1'b0, 1'b0, '0, 1'b0, '0, '0);
        e.data = d; e.irq = irq; e.tag = tag;
        sb.push_back(e);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk(3'd3, 32'h0, 1'b0, "R1 status");
        chk(3'd5, 32'h0, 1'b0, "R1 enable");
        chk(3'd0, 32'h0, 1'b0, "R1 addr lo");
        chk(3'd1, 32'h0, 1'b0, "R1 addr hi");
        // R2/R5: event latches without enable, no irq
        drive(1'b0, 3'd0, '0, 1'b1, 1'b0, '0, 1'b0, '0, '0);
        chk(3'd3, 32'h1, 1'b0, "R2 dev event, R5 masked");
        // R3/R5: enable bit 0 raises irq
        wr(3'd5, 32'h1);
        chk(3'd5, 32'h1, 1'b1, "R3 enable set, R5 irq");
        wr(3'd5, 32'h2);
        chk(3'd5, 32'h3, 1'b1, "R3 enable OR");
        // R6: write one clears
        wr(3'd3, 32'h1);
        chk(3'd3, 32'h0, 1'b0, "R6 clear bit0");
        // R8: first bus error captured
        drive(1'b0, 3'd0, '0, 1'b0, 1'b1, 64'h0000_00AB_1234_5678, 1'b0, '0, '0);
        chk(3'd3, 32'h2, 1'b1, "R2 bus error bit");
        chk(3'd0, 32'h1234_5678, 1'b1, "R8 addr lo");
        chk(3'd1, 32'h0000_00AB, 1'b1, "R8 addr hi");
        drive(1'b0, 3'd0, '0, 1'b0, 1'b1, 64'hFFFF_0000_0000_0001, 1'b0, '0, '0);
        chk(3'd0, 32'h1234_5678, 1'b1, "R8 first fault kept");
        // R6: clear bit1 with bit0 zero, then new fault captured
        wr(3'd3, 32'h2);
        chk(3'd3, 32'h0, 1'b0, "R6 clear bit1");
        drive(1'b0, 3'd0, '0, 1'b0, 1'b1, 64'h0000_0001_DEAD_BEEF, 1'b0, '0, '0);
        chk(3'd0, 32'hDEAD_BEEF, 1'b1, "R8 recapture lo");
        chk(3'd1, 32'h0000_0001, 1'b1, "R8 recapture hi");
        wr(3'd3, 32'h3);
        chk(3'd3, 32'h0, 1'b0, "R6 clear both");
        // R7: event same cycle as clear
        drive(1'b1, 3'd3, 32'h1, 1'b1, 1'b0, '0, 1'b0, '0, '0);
        chk(3'd3, 32'h1, 1'b1, "R7 event beats clear");
        // R10: busy byte, wrong address
        drive(1'b0, 3'd0, '0, 1'b0, 1'b0, '0, 1'b1, 12'h11C, 8'h80);
        chk(3'd3, 32'h1, 1'b1, "R10 busy byte ignored");
        drive(1'b0, 3'd0, '0, 1'b0, 1'b0, '0, 1'b1, 12'h120, 8'h50);
        chk(3'd3, 32'h1, 1'b1, "R10 other address ignored");
        // R9: ready snoop clears
        drive(1'b0, 3'd0, '0, 1'b0, 1'b0, '0, 1'b1, 12'h11C, 8'h40);
        chk(3'd3, 32'h0, 1'b0, "R9 snoop clear");
        drive(1'b0, 3'd0, '0, 1'b0, 1'b1, 64'h0000_0002_0000_0002, 1'b0, '0, '0);
        chk(3'd1, 32'h2, 1'b1, "R8 capture after snoop");
        drive(1'b0, 3'd0, '0, 1'b1, 1'b0, '0, 1'b1, 12'h11C, 8'h01);
        chk(3'd3, 32'h1, 1'b1, "R9 snoop clears bit1, R7 dev kept");
        // R4: enable clear masks irq, status stays
        wr(3'd7, 32'h1);
        chk(3'd5, 32'h2, 1'b0, "R4 enable clear");
        chk(3'd3, 32'h1, 1'b0, "R4 status held, R5 masked");
        // R11: writes to address words ignored, unused indices zero
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        chk(3'd0, 32'h2, 1'b0, "R11 addr lo write ignored");
        chk(3'd1, 32'h2, 1'b0, "R11 addr hi write ignored");
        chk(3'd2, 32'h0, 1'b0, "R11 index 2 zero");
        chk(3'd4, 32'h0, 1'b0, "R11 index 4 zero");
        chk(3'd6, 32'h0, 1'b0, "R11 index 6 zero");
        drive(1'b0, 3'd0, '0, 1'b0, 1'b0, '0, 1'b0, '0, '0);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule